// File: doc/BRIEF.md
# One-Time-Erasable Byte ROM Device Model

A synthesizable, clock-based model of a 128K x 8 ultraviolet-erasable programmable ROM. It serves as the target device when a programmer or a test sequencer is verified. Active-low chip, output and program enables, together with two level flags, select the operating mode. One flag says that the programming supply is present. The other says that a high voltage sits on address bit 9. Analog levels and access delays are not modelled. The bidirectional data bus appears as three signals: an input byte, an output byte and an output-enable. The output-enable is low whenever the pins would float.

Only the low `MEM_BITS` address bits index the storage, so the array can be shrunk for simulation and upper address bits alias. Programming only clears bits: the new byte is the old byte ANDed with the input byte. A write takes effect only after `PULSES` consecutive clock edges of an unbroken program pulse. This models cells that need repeated pulses. Page programming first collects up to four bytes in a page buffer and then burns them in one pulse. An identifier mode returns a maker code and a device code. The erase input restores every byte to 0xFF.

The pulse controller is a state machine with the states `ST_IDLE`, `ST_CELL_PULSE`, `ST_CELL_HELD`, `ST_PAGE_PULSE` and `ST_PAGE_HELD`. It has these transitions:
- *cell start*: from IDLE to CELL_PULSE, or to CELL_HELD when `PULSES`=1.
- *cell count*: CELL_PULSE stays in CELL_PULSE and increments its count.
- *cell commit*: from CELL_PULSE to CELL_HELD. The byte is written on this edge.
- *cell abort* and *cell release*: from CELL_PULSE or CELL_HELD back to IDLE, when the mode or the address changes.
- The page transitions are the same four (start, count, commit, abort/release), with the page number in place of the full address.

Top module: `uvrom_model`

## Requirements
- R1: After reset every location reads 0xFF. A one-cycle `uv_erase` pulse returns every location to 0xFF by the next cycle.
- R2: With `vpp_ok`=0 and `a9_hv`=0, the pattern chip_en_n=0, out_en_n=0, prog_en_n=1 reads: `d_oe`=1 and `d_out` is the stored byte. chip_en_n=1 (standby), out_en_n=1 (output disable), or all three enables low without supply, each give `d_oe`=0.
- R3: With `vpp_ok`=1, chip_en_n=0, out_en_n=1, prog_en_n=0 held at one address for `PULSES` clock edges programs that byte from `d_in`. `d_oe` is 0 during the pulse.
- R4: A program pulse of fewer than `PULSES` edges, or one whose address changes before the count completes, leaves the array unchanged.
- R5: Programming only clears bits: the stored result is the old byte AND `d_in`.
- R6: With `vpp_ok`=1, chip_en_n=0, out_en_n=0, prog_en_n=1 (verify), `d_oe`=1 and `d_out` is the stored byte.
- R7: With `vpp_ok`=1 and all three enables low (inhibit), `d_oe`=0 and nothing is written, however long the pattern is held.
- R8: With `vpp_ok`=1, chip_en_n=1, out_en_n=0, prog_en_n=1 (page load), `d_in` goes into page-buffer slot `a[1:0]`. `d_oe`=0 and the array is unchanged.
- R9: With `vpp_ok`=1, chip_en_n=1, out_en_n=1, prog_en_n=0 for `PULSES` edges, each of the four bytes of page `a[16:2]` is ANDed with its buffer slot. Slots that were not loaded hold 0xFF. The buffer returns to all 0xFF after the burn, and `d_oe` is 0.
- R10: With `vpp_ok`=0, `a9_hv`=1 and the read enables, `d_oe`=1. `a[0]`=0 gives 0x07. `a[0]`=1 gives 0x38 when `ALT_PINOUT`=0 and 0xB9 when `ALT_PINOUT`=1. All other address bits are ignored.
- R11: Address bits at or above `MEM_BITS` are ignored, so addresses that differ only in those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Synchronous active-low reset (erased state) |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| prog_en_n | input | 1 | Program enable, active low |
| a | input | 17 | Byte address |
| d_in | input | 8 | Data bus, input side |
| d_out | output | 8 | Data bus, output side |
| d_oe | output | 1 | Data bus driven when 1 |
| a9_hv | input | 1 | High voltage present on address bit 9 |
| vpp_ok | input | 1 | Programming supply present |
| uv_erase | input | 1 | Erase whole array to 0xFF |

## Verification
The bench builds the model with `MEM_BITS`=6 and `PULSES`=3. The 64-byte array makes aliasing of high address bits easy to reach, and a three-edge pulse separates a short, aborted pulse from a complete one. A second instance with `ALT_PINOUT`=1 shares every input, so both device codes are compared under the same identifier stimulus. The page test loads only some buffer slots, so it shows both the ANDing of loaded slots and the no-effect of slots that were left at 0xFF.

// File: rtl/uvrom_pkg.sv
package uvrom_pkg;

    typedef enum logic [3:0] {
        MD_STANDBY,
        MD_QUIET,
        MD_READ,
        MD_IDENT,
        MD_PROG,
        MD_VERIFY,
        MD_INHIBIT,
        MD_PG_LOAD,
        MD_PG_BURN
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CELL_PULSE,
        ST_CELL_HELD,
        ST_PAGE_PULSE,
        ST_PAGE_HELD
    } burn_st_e;

    localparam int          PAGE_BITS    = 2;
    localparam logic [7:0]  MAKER_CODE   = 8'h07;
    localparam logic [7:0]  DEV_CODE_STD = 8'h38;
    localparam logic [7:0]  DEV_CODE_ALT = 8'hB9;

endpackage

// File: rtl/uvrom_mode_dec.sv
module uvrom_mode_dec
    import uvrom_pkg::*;
(
    input  logic  chip_en_n,
    input  logic  out_en_n,
    input  logic  prog_en_n,
    input  logic  a9_hv,
    input  logic  vpp_ok,
    output mode_e mode
);
    always_comb begin
        mode = MD_STANDBY;
        if (!vpp_ok) begin
            if (chip_en_n)       mode = MD_STANDBY;
            else if (out_en_n)   mode = MD_QUIET;
            else if (!prog_en_n) mode = MD_QUIET;
            else if (a9_hv)      mode = MD_IDENT;
            else                 mode = MD_READ;
        end else begin
            unique case ({chip_en_n, out_en_n, prog_en_n})
                3'b010:  mode = MD_PROG;
                3'b001:  mode = MD_VERIFY;
                3'b000:  mode = MD_INHIBIT;
                3'b101:  mode = MD_PG_LOAD;
                3'b110:  mode = MD_PG_BURN;
                3'b011:  mode = MD_QUIET;
                default: mode = MD_STANDBY;
            endcase
        end
    end
endmodule

// File: rtl/uvrom_burn_fsm.sv
module uvrom_burn_fsm
    import uvrom_pkg::*;
#(
    parameter int PULSES = 4,
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] addr,
    output logic              cell_wr,
    output logic              page_wr
);
    localparam int              CNT_W = $clog2(PULSES) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSES - 1);
    localparam bit              ONE_SHOT = (PULSES == 1);

    burn_st_e          st, st_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [ADDR_W-1:0] cap, cap_nx;
    logic              same_addr, same_page;

    assign same_addr = (addr == cap);
    assign same_page = (addr[ADDR_W-1:PAGE_BITS] == cap[ADDR_W-1:PAGE_BITS]);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            cap <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            cap <= cap_nx;
        end
    end

    // next state
    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        cap_nx = cap;
        unique case (st)
            ST_IDLE: begin
                cap_nx = addr;
                cnt_nx = CNT_W'(1);
                if (mode == MD_PROG)
                    st_nx = ONE_SHOT ? ST_CELL_HELD : ST_CELL_PULSE;
                else if (mode == MD_PG_BURN)
                    st_nx = ONE_SHOT ? ST_PAGE_HELD : ST_PAGE_PULSE;
            end
            ST_CELL_PULSE: begin
                if (mode != MD_PROG || !same_addr) st_nx = ST_IDLE;
                else if (cnt == LAST)              st_nx = ST_CELL_HELD;
                else                               cnt_nx = cnt + CNT_W'(1);
            end
            ST_CELL_HELD: begin
                if (mode != MD_PROG || !same_addr) st_nx = ST_IDLE;
            end
            ST_PAGE_PULSE: begin
                if (mode != MD_PG_BURN || !same_page) st_nx = ST_IDLE;
                else if (cnt == LAST)                 st_nx = ST_PAGE_HELD;
                else                                  cnt_nx = cnt + CNT_W'(1);
            end
            ST_PAGE_HELD: begin
                if (mode != MD_PG_BURN || !same_page) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cell_wr = 1'b0;
        page_wr = 1'b0;
        unique case (st)
            ST_IDLE: begin
                cell_wr = ONE_SHOT && (mode == MD_PROG);
                page_wr = ONE_SHOT && (mode == MD_PG_BURN);
            end
            ST_CELL_PULSE: cell_wr = (mode == MD_PROG) && same_addr && (cnt == LAST);
            ST_PAGE_PULSE: page_wr = (mode == MD_PG_BURN) && same_page && (cnt == LAST);
            default: ;
        endcase
    end

    assert_inhibit_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_INHIBIT) |-> (!cell_wr && !page_wr));

    assert_cell_pulse_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_wr && !ONE_SHOT) |-> ($past(mode) == MD_PROG && $past(addr) == addr));

    assert_page_pulse_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (page_wr && !ONE_SHOT) |-> ($past(mode) == MD_PG_BURN));

    assert_single_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cell_wr |=> !cell_wr);
endmodule

// File: rtl/uvrom_page_buf.sv
module uvrom_page_buf
    import uvrom_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [PAGE_BITS-1:0]          slot,
    input  logic [DATA_W-1:0]             din,
    input  logic                          clear,
    output logic [(1<<PAGE_BITS)*DATA_W-1:0] slots
);
    localparam int SLOTS = 1 << PAGE_BITS;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            slots <= '1;
        end else if (load) begin
            slots[slot*DATA_W +: DATA_W] <= din;
        end
    end

    assert_buf_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> (slots == {SLOTS*DATA_W{1'b1}}));
endmodule

// File: rtl/uvrom_array.sv
module uvrom_array
    import uvrom_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          erase,
    input  logic                          cell_wr,
    input  logic [IDX_W-1:0]              cell_idx,
    input  logic [DATA_W-1:0]             cell_data,
    input  logic                          page_wr,
    input  logic [IDX_W-PAGE_BITS-1:0]    page_sel,
    input  logic [(1<<PAGE_BITS)*DATA_W-1:0] page_data,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int SLOTS = 1 << PAGE_BITS;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            if (cell_wr)
                mem[cell_idx] <= mem[cell_idx] & cell_data;
            if (page_wr)
                for (int s = 0; s < SLOTS; s++)
                    mem[{page_sel, PAGE_BITS'(s)}] <=
                        mem[{page_sel, PAGE_BITS'(s)}] & page_data[s*DATA_W +: DATA_W];
        end
    end

    assign rd_data = mem[rd_idx];

    assert_erase_all_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (rd_data == {DATA_W{1'b1}}));

    assert_clear_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_wr && !erase && rd_idx == cell_idx) |=>
            (!$stable(rd_idx) || ((rd_data & ~$past(rd_data)) == '0)));
endmodule

// File: rtl/uvrom_model.sv
module uvrom_model
    import uvrom_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int MEM_BITS   = 8,
    parameter int PULSES     = 4,
    parameter bit ALT_PINOUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              prog_en_n,
    input  logic [ADDR_W-1:0] a,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] d_out,
    output logic              d_oe,
    input  logic              a9_hv,
    input  logic              vpp_ok,
    input  logic              uv_erase
);
    localparam int              BUF_W   = (1 << PAGE_BITS) * DATA_W;
    localparam logic [DATA_W-1:0] DEV_ID = ALT_PINOUT ? DATA_W'(DEV_CODE_ALT)
                                                      : DATA_W'(DEV_CODE_STD);
    localparam logic [DATA_W-1:0] MK_ID  = DATA_W'(MAKER_CODE);

    mode_e             mode;
    logic              cell_wr, page_wr;
    logic [BUF_W-1:0]  buf_bytes;
    logic [DATA_W-1:0] rd_data;

    uvrom_mode_dec u_dec (
        .chip_en_n (chip_en_n),
        .out_en_n  (out_en_n),
        .prog_en_n (prog_en_n),
        .a9_hv     (a9_hv),
        .vpp_ok    (vpp_ok),
        .mode      (mode)
    );

    uvrom_burn_fsm #(.PULSES(PULSES), .ADDR_W(ADDR_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .addr    (a),
        .cell_wr (cell_wr),
        .page_wr (page_wr)
    );

    uvrom_page_buf #(.DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mode == MD_PG_LOAD),
        .slot  (a[PAGE_BITS-1:0]),
        .din   (d_in),
        .clear (page_wr),
        .slots (buf_bytes)
    );

    uvrom_array #(.IDX_W(MEM_BITS), .DATA_W(DATA_W)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase     (uv_erase),
        .cell_wr   (cell_wr),
        .cell_idx  (a[MEM_BITS-1:0]),
        .cell_data (d_in),
        .page_wr   (page_wr),
        .page_sel  (a[MEM_BITS-1:PAGE_BITS]),
        .page_data (buf_bytes),
        .rd_idx    (a[MEM_BITS-1:0]),
        .rd_data   (rd_data)
    );

    // bus drive
    always_comb begin
        d_oe  = 1'b0;
        d_out = '0;
        unique case (mode)
            MD_READ, MD_VERIFY: begin
                d_oe  = 1'b1;
                d_out = rd_data;
            end
            MD_IDENT: begin
                d_oe  = 1'b1;
                d_out = a[0] ? DEV_ID : MK_ID;
            end
            default: ;
        endcase
    end

    assert_standby_float_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chip_en_n |-> !d_oe);

    assert_prog_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_ok && out_en_n) |-> !d_oe);

    assert_ident_maker_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_ok && a9_hv && !chip_en_n && !out_en_n && prog_en_n && !a[0])
            |-> (d_oe && d_out == MK_ID));
endmodule

// File: tb/uvrom_model_tb.sv
module uvrom_model_tb;
    localparam int MB = 6;
    localparam int NP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, pg_n = 1'b1;
    logic [16:0] a = '0;
    logic [7:0]  din = '0;
    logic        hv = 1'b0, vpp = 1'b0, ers = 1'b0;
    logic [7:0]  dout, dout_alt;
    logic        doe, doe_alt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    uvrom_model #(.MEM_BITS(MB), .PULSES(NP), .ALT_PINOUT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en_n(ce_n), .out_en_n(oe_n), .prog_en_n(pg_n),
        .a(a), .d_in(din), .d_out(dout), .d_oe(doe), .a9_hv(hv), .vpp_ok(vpp), .uv_erase(ers));

    uvrom_model #(.MEM_BITS(MB), .PULSES(NP), .ALT_PINOUT(1'b1)) u_alt (
        .clk(clk), .rst_n(rst_n), .chip_en_n(ce_n), .out_en_n(oe_n), .prog_en_n(pg_n),
        .a(a), .d_in(din), .d_out(dout_alt), .d_oe(doe_alt), .a9_hv(hv), .vpp_ok(vpp), .uv_erase(ers));

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic pins(input logic c, input logic o, input logic p, input logic h,
                        input logic v, input logic [16:0] ad, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; pg_n = p; hv = h; vpp = v; a = ad; din = d;
        #1;
    endtask

    task automatic read_exp(input string tag, input logic [16:0] ad, input logic [7:0] exp);
        pins(0, 0, 1, 0, 0, ad, 8'h00);
        chk({tag, " oe"}, {7'd0, doe}, 8'h01);
        chk(tag, dout, exp);
    endtask

    task automatic prog_cell(input logic [16:0] ad, input logic [7:0] d, input int n);
        pins(0, 1, 0, 0, 1, ad, d);
        chk("R3 bus floats while programming", {7'd0, doe}, 8'h00);
        repeat (n) @(posedge clk);
        pins(0, 1, 1, 0, 1, ad, d);
    endtask

    task automatic t_reset;
        read_exp("R1 reset loc0", 17'd0, 8'hFF);
        read_exp("R1 reset loc5", 17'd5, 8'hFF);
        read_exp("R1 reset loc63", 17'd63, 8'hFF);
    endtask

    task automatic t_read_modes;
        pins(1, 0, 1, 0, 0, 17'd0, 0);
        chk("R2 standby float", {7'd0, doe}, 8'h00);
        pins(0, 1, 1, 0, 0, 17'd0, 0);
        chk("R2 output disable float", {7'd0, doe}, 8'h00);
        pins(0, 0, 0, 0, 0, 17'd0, 0);
        chk("R2 all low no supply float", {7'd0, doe}, 8'h00);
    endtask

    task automatic t_program;
        prog_cell(17'd5, 8'hA5, NP);
        read_exp("R3 programmed byte", 17'd5, 8'hA5);
        pins(0, 0, 1, 0, 1, 17'd5, 0);
        chk("R6 verify oe", {7'd0, doe}, 8'h01);
        chk("R6 verify data", dout, 8'hA5);
    endtask

    task automatic t_short_abort;
        prog_cell(17'd6, 8'h00, NP - 1);
        read_exp("R4 short pulse no write", 17'd6, 8'hFF);
        pins(0, 1, 0, 0, 1, 17'd7, 8'h00);
        repeat (NP - 1) @(posedge clk);
        pins(0, 1, 0, 0, 1, 17'd8, 8'h00);
        @(posedge clk);
        pins(0, 1, 1, 0, 1, 17'd8, 8'h00);
        read_exp("R4 aborted addr A", 17'd7, 8'hFF);
        read_exp("R4 aborted addr B", 17'd8, 8'hFF);
    endtask

    task automatic t_and_only;
        prog_cell(17'd9, 8'hF0, NP);
        prog_cell(17'd9, 8'h3C, NP);
        read_exp("R5 AND of two writes", 17'd9, 8'h30);
        prog_cell(17'd9, 8'hFF, NP);
        read_exp("R5 ones cannot set bits", 17'd9, 8'h30);
    endtask

    task automatic t_inhibit;
        pins(0, 0, 0, 0, 1, 17'd10, 8'h00);
        chk("R7 inhibit float", {7'd0, doe}, 8'h00);
        repeat (2 * NP) @(posedge clk);
        read_exp("R7 inhibit no write", 17'd10, 8'hFF);
    endtask

    task automatic t_page;
        pins(1, 0, 1, 0, 1, 17'h10, 8'h11);
        chk("R8 load float", {7'd0, doe}, 8'h00);
        pins(1, 0, 1, 0, 1, 17'h12, 8'h22);
        pins(1, 1, 1, 0, 1, 17'h12, 8'h00);
        read_exp("R8 load leaves array", 17'h10, 8'hFF);
        pins(1, 1, 0, 0, 1, 17'h10, 8'h00);
        chk("R9 burn float", {7'd0, doe}, 8'h00);
        repeat (NP) @(posedge clk);
        pins(1, 1, 1, 0, 1, 17'h10, 8'h00);
        read_exp("R9 slot0", 17'h10, 8'h11);
        read_exp("R9 slot1 unloaded", 17'h11, 8'hFF);
        read_exp("R9 slot2", 17'h12, 8'h22);
        read_exp("R9 slot3 unloaded", 17'h13, 8'hFF);
        pins(1, 1, 0, 0, 1, 17'h20, 8'h00);
        repeat (NP) @(posedge clk);
        pins(1, 1, 1, 0, 1, 17'h20, 8'h00);
        read_exp("R9 buffer cleared after burn", 17'h20, 8'hFF);
        read_exp("R9 buffer cleared slot2", 17'h22, 8'hFF);
    endtask

    task automatic t_ident;
        pins(0, 0, 1, 1, 0, 17'h00000, 0);
        chk("R10 maker std", dout, 8'h07);
        chk("R10 maker alt", dout_alt, 8'h07);
        pins(0, 0, 1, 1, 0, 17'h00001, 0);
        chk("R10 device std", dout, 8'h38);
        chk("R10 device alt", dout_alt, 8'hB9);
        chk("R10 ident oe", {7'd0, doe}, 8'h01);
        pins(0, 0, 1, 1, 0, 17'h1FFFE, 0);
        chk("R10 high bits ignored maker", dout, 8'h07);
        pins(0, 0, 1, 1, 0, 17'h12345, 0);
        chk("R10 high bits ignored device", dout_alt, 8'hB9);
    endtask

    task automatic t_alias;
        read_exp("R11 alias +64", 17'd69, 8'hA5);
        read_exp("R11 alias top bit", 17'h10005, 8'hA5);
    endtask

    task automatic t_erase;
        @(negedge clk); ers = 1'b1;
        @(negedge clk); ers = 1'b0;
        read_exp("R1 erase loc5", 17'd5, 8'hFF);
        read_exp("R1 erase loc9", 17'd9, 8'hFF);
        read_exp("R1 erase page", 17'h12, 8'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_read_modes();
        t_program();
        t_short_abort();
        t_and_only();
        t_inhibit();
        t_page();
        t_ident();
        t_alias();
        t_erase();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule